// File: doc/BRIEF.md
# Chained Serial Configuration Loader

This block takes a configuration word one bit at a time on a serial data pin. On each rising edge of the serial clock it samples one bit, but only while its active-low serial enable input is low. An internal counter tracks how many bits have arrived. When the full word is in, the block enters its programmed state and holds the word for the logic around it.

The serial enable output is the completion signal. It stays high while the device is still loading. Once the device is programmed, the output follows the enable input. A low output therefore tells the system that this device is ready for normal reads and writes, and it also opens the next device in a daisy chain, whose enable input is wired to this output. Every device in the chain runs on the same serial clock. A default-programming input lets a device skip the shifting and load a built-in default word instead.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cfg_done` is 0, `cfg_word` is all zeros and `sen_out_n` is 1. Reset is asynchronous and active low.
- R2: A bit is taken from `sdi` on a rising `sclk` edge only when `sen_in_n` is 0 and the device is not yet programmed. Bits enter at bit 0 and move toward the MSB. After all CFG_BITS bits have arrived, the first bit sits at bit CFG_BITS-1 and the last bit at bit 0.
- R3: While `cfg_done` is 0, `sen_out_n` is 1 whatever `sen_in_n` does.
- R4: `cfg_done` rises on exactly the edge that captures the CFG_BITS-th bit, and not on any earlier edge.
- R5: Once `cfg_done` is 1, `sen_out_n` equals `sen_in_n` with no clock delay. It goes low when the input goes low and high when the input is released.
- R6: If `cfg_default` is 1 on a rising edge while the device is not programmed, `cfg_done` becomes 1 and `cfg_word` becomes DEFAULT_CFG. This takes priority over a shift on the same edge.
- R7: After `cfg_done` is 1, further `sdi` bits, `sen_in_n` activity and `cfg_default` pulses do not change `cfg_word` or `cfg_done` until the next reset.
- R8: Edges with `sen_in_n` high during loading keep the partial word and the bit count. Loading continues from the same place when the enable returns low.
- R9: A reset in the middle of a load discards the partial word and the count. A later load starts again from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, shared by the whole chain |
| rst_n | input | 1 | Asynchronous master reset, active low |
| cfg_default | input | 1 | Load DEFAULT_CFG and finish without shifting |
| sen_in_n | input | 1 | Serial enable input, active low |
| sdi | input | 1 | Serial configuration data |
| sen_out_n | output | 1 | Serial enable output to the next device; low means programmed and enabled |
| cfg_done | output | 1 | Device is programmed |
| cfg_word | output | CFG_BITS | Loaded configuration word |

## Verification
The assertions assume that `sen_in_n`, `sdi` and `cfg_default` change only away from the rising `sclk` edge. They also assume that `rst_n` is released away from that edge. The stimulus meets this by changing every input on the falling edge. The shift-hold property assumes the enable is the only thing that gates sampling. The stimulus therefore toggles `sdi` freely during paused and post-completion stretches, so that an ungated register would be caught. The combinational pass-through is checked one nanosecond after each input change, before the next rising edge.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic {
    ST_LOADING    = 1'b0,
    ST_PROGRAMMED = 1'b1
  } prog_state_e;

endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int CFG_BITS = 64,
  parameter int CNT_W    = $clog2(CFG_BITS + 1)
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             last_bit
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CFG_BITS);

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] cur);
    return cur + CNT_W'(1);
  endfunction

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= count_after(count);
    end
  end

  assign last_bit = (count == LAST_IDX);

  p_count_bound_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_count_step_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    !step |=> $stable(count));

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int                  CFG_BITS    = 64,
  parameter logic [CFG_BITS-1:0] DEFAULT_CFG = 64'hA5C3_0F96_1E2D_3C4B
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                load_default,
  input  logic                sdi,
  output logic [CFG_BITS-1:0] word
);

  function automatic logic [CFG_BITS-1:0] shift_in(input logic [CFG_BITS-1:0] cur,
                                                   input logic                bit_in);
    return {cur[CFG_BITS-2:0], bit_in};
  endfunction

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (load_default) begin
      word <= DEFAULT_CFG;
    end else if (shift_en) begin
      word <= shift_in(word, sdi);
    end
  end

  p_hold_when_idle_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    (!shift_en && !load_default) |=> $stable(word));

  p_default_load_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    load_default |=> (word == DEFAULT_CFG));

endmodule

// File: rtl/cfg_done_ctrl.sv
module cfg_done_ctrl
  import cfg_ld_pkg::*;
(
  input  logic sclk,
  input  logic rst_n,
  input  logic sen_in_n,
  input  logic cfg_default,
  input  logic last_bit,
  output logic shift_en,
  output logic load_default,
  output logic done
);

  prog_state_e state_q;
  prog_state_e state_d;
  logic        loading;
  logic        finish_shift;

  assign loading      = (state_q == ST_LOADING);
  assign load_default = loading && cfg_default;
  assign shift_en     = loading && !sen_in_n && !cfg_default;
  assign finish_shift = shift_en && last_bit;

  always_comb begin
    state_d = state_q;
    if (load_default || finish_shift) begin
      state_d = ST_PROGRAMMED;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOADING;
    end else begin
      state_q <= state_d;
    end
  end

  assign done = (state_q == ST_PROGRAMMED);

  p_done_on_last_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    finish_shift |=> done);

  p_done_sticky_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    done |=> done);

  p_no_shift_after_done_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    done |-> (!shift_en && !load_default));

  p_default_wins_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    load_default |-> !shift_en);

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int                  CFG_BITS    = 64,
  parameter logic [CFG_BITS-1:0] DEFAULT_CFG = 64'hA5C3_0F96_1E2D_3C4B
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                cfg_default,
  input  logic                sen_in_n,
  input  logic                sdi,
  output logic                sen_out_n,
  output logic                cfg_done,
  output logic [CFG_BITS-1:0] cfg_word
);

  localparam int CNT_W = $clog2(CFG_BITS + 1);

  logic             shift_en;
  logic             load_default;
  logic             last_bit;
  logic [CNT_W-1:0] bit_count;

  cfg_done_ctrl u_ctrl (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .sen_in_n     (sen_in_n),
    .cfg_default  (cfg_default),
    .last_bit     (last_bit),
    .shift_en     (shift_en),
    .load_default (load_default),
    .done         (cfg_done)
  );

  cfg_bit_counter #(
    .CFG_BITS (CFG_BITS),
    .CNT_W    (CNT_W)
  ) u_count (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .step     (shift_en),
    .count    (bit_count),
    .last_bit (last_bit)
  );

  cfg_shift_reg #(
    .CFG_BITS    (CFG_BITS),
    .DEFAULT_CFG (DEFAULT_CFG)
  ) u_shift (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .load_default (load_default),
    .sdi          (sdi),
    .word         (cfg_word)
  );

  assign sen_out_n = cfg_done ? sen_in_n : 1'b1;

  p_out_high_loading_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    !cfg_done |-> sen_out_n);

  p_release_follows_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    (cfg_done && sen_in_n) |-> sen_out_n);

  p_word_frozen_r7: assert property (@(posedge sclk) disable iff (!rst_n)
    cfg_done |=> $stable(cfg_word));

endmodule

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;

  localparam int          N      = 64;
  localparam logic [63:0] DEFW   = 64'h3C96_F00D_5AA5_0E71;
  localparam int          LIMIT  = 20000;

  logic          sclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_default = 1'b0;
  logic          sen_in_n = 1'b1;
  logic          sdi = 1'b0;
  logic          sen_out_n;
  logic          cfg_done;
  logic [N-1:0]  cfg_word;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    finished = 0;
  string tag = "R1";

  bit    rx_q[$];
  bit    m_done = 0;
  bit    m_def  = 0;

  always #2.5 sclk = ~sclk;

  serial_cfg_loader #(
    .CFG_BITS    (N),
    .DEFAULT_CFG (DEFW)
  ) u_serial_cfg_loader (
    .sclk        (sclk),
    .rst_n       (rst_n),
    .cfg_default (cfg_default),
    .sen_in_n    (sen_in_n),
    .sdi         (sdi),
    .sen_out_n   (sen_out_n),
    .cfg_done    (cfg_done),
    .cfg_word    (cfg_word)
  );

  // behavioural reference: a queue of received bits plus two flags
  always @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q.delete();
      m_done = 0;
      m_def  = 0;
    end else if (!m_done) begin
      if (cfg_default) begin
        m_done = 1;
        m_def  = 1;
      end else if (!sen_in_n) begin
        rx_q.push_back(sdi);
        if (rx_q.size() == N) m_done = 1;
      end
    end
  end

  function automatic logic [N-1:0] expected_word();
    logic [N-1:0] w = '0;
    int k = rx_q.size();
    if (m_def) return DEFW;
    foreach (rx_q[j]) w[k-1-j] = rx_q[j];
    return w;
  endfunction

  task automatic compare();
    logic [N-1:0] ew = expected_word();
    logic         eo = m_done ? sen_in_n : 1'b1;
    vectors++;
    if (cfg_word !== ew) begin
      errors++;
      $display("FAIL %s cfg_word act=%h exp=%h", tag, cfg_word, ew);
    end
    if (cfg_done !== m_done) begin
      errors++;
      $display("FAIL %s cfg_done act=%b exp=%b", tag, cfg_done, m_done);
    end
    if (sen_out_n !== eo) begin
      errors++;
      $display("FAIL %s sen_out_n act=%b exp=%b", tag, sen_out_n, eo);
    end
  endtask

  // compare on the falling edge, then drive the next inputs
  task automatic step(input logic en_n, input logic d, input logic def);
    @(negedge sclk);
    compare();
    sen_in_n    = en_n;
    sdi         = d;
    cfg_default = def;
    #1;
    if (m_done) begin
      // R5: pass-through without a clock edge
      vectors++;
      if (sen_out_n !== en_n) begin
        errors++;
        $display("FAIL R5 sen_out_n act=%b exp=%b", sen_out_n, en_n);
      end
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge sclk);
    rst_n = 1'b0;
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    @(negedge sclk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge sclk) begin
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=%0d cycles", cycles, LIMIT);
      summary();
    end
  end

  initial begin
    // R1: reset state, held and released
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0);
    @(negedge sclk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b0);

    // R2 and R3: first 20 bits, output must stay high
    tag = "R2_R3";
    for (int i = 0; i < 20; i++) step(1'b0, 1'($urandom_range(0, 1)), 1'b0);

    // R8: pause with sdi toggling
    tag = "R8";
    for (int i = 0; i < 6; i++) step(1'b1, 1'(i & 1), 1'b0);

    // R4: remaining bits, done exactly on the last one
    tag = "R4";
    for (int i = 0; i < N - 20; i++) step(1'b0, 1'($urandom_range(0, 1)), 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // R5: enable pass-through both directions
    tag = "R5";
    for (int i = 0; i < 8; i++) step(1'(i % 3 == 0), 1'b0, 1'b0);

    // R7: extra bits and default pulses ignored
    tag = "R7";
    for (int i = 0; i < 12; i++) step(1'b0, 1'($urandom_range(0, 1)), 1'(i == 5));

    // R9: reset in the middle of a load
    tag = "R9";
    do_reset(2);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0);
    do_reset(2);
    for (int i = 0; i < N + 3; i++) step(1'b0, 1'(i % 5 == 1), 1'b0);
    step(1'b1, 1'b0, 1'b0);

    // R6: default load beats a shift on the same edge
    tag = "R6";
    do_reset(1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    tag = "R6_R5";
    for (int i = 0; i < 6; i++) step(1'(i & 1), 1'b1, 1'b0);

    // R6: default with enable high, no bits at all
    tag = "R6";
    do_reset(1);
    step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'(i < 2), 1'b1, 1'b0);

    summary();
  end

endmodule